// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block lets logic running on a single clock read and write a 32K x 8 asynchronous static RAM. The system side offers one transaction at a time through a valid/ready request port that carries an address, write data and a write flag. Completion is reported by a one-cycle response strobe, and for reads that strobe carries the captured byte. The memory side drives three active-low strobes (chip select, output enable, write enable) and a 15-bit address. The data bus is presented as the three signals of a pad-level tristate: a drive value, a drive enable and the value sampled from the pins.

The RAM has no clock, so every access is stretched over a whole number of clock cycles. The wait counts are parameters, each computed as the ceiling of a timing value in picoseconds divided by the clock period. With a 5 ns clock and the fast speed grade the defaults are as follows:

- a read keeps output enable low for 5 cycles;
- a read is followed by a 3-cycle bus-release gap;
- a write pulse lasts 4 cycles.

Between transactions the controller deselects the RAM so that it rests in standby.

Top module: `asram_ctrl`

## Requirements
- R1: After synchronous reset, mem_ce_n, mem_oe_n and mem_we_n are 1, mem_dq_oe is 0, req_ready is 1 and rsp_valid is 0.
- R2: In every cycle where req_ready is 1 the RAM is deselected (mem_ce_n = 1) and the controller does not drive the data bus (mem_dq_oe = 0).
- R3: A read accepted at a clock edge puts mem_ce_n = 0, mem_oe_n = 0, mem_we_n = 1 and mem_addr = the request address in the next cycle. This holds unchanged for 5 cycles (the access count), so rsp_valid is seen 6 cycles after acceptance.
- R4: The read result is the value on mem_dq_i during the last cycle of the output-enable window. It appears on rsp_rdata with a one-cycle rsp_valid pulse in the cycle where mem_oe_n and mem_ce_n return to 1.
- R5: After a read, req_ready stays 0 for 3 cycles (the release count) starting with the cycle in which mem_oe_n rises, and returns to 1 in the cycle after that.
- R6: mem_dq_oe is never 1 while the RAM could be driving: not while mem_ce_n, mem_oe_n are 0 and mem_we_n is 1, and not in the release cycles that follow. mem_oe_n and mem_we_n are never both 0.
- R7: In the first cycle of a write, mem_ce_n = 0, mem_we_n = 1, mem_oe_n = 1 and mem_dq_oe = 1, with mem_addr and mem_dq_o already carrying the request values. mem_we_n falls in the next cycle.
- R8: mem_we_n stays 0 for exactly 4 cycles (the write pulse count). mem_addr and mem_dq_o stay unchanged over the pulse and mem_oe_n stays 1.
- R9: mem_we_n rises one cycle before mem_dq_oe falls and mem_ce_n rises. rsp_valid pulses in the cycle the bus is released, 7 cycles after the write was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken at this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Request address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle completion strobe |
| rsp_rdata | output | 8 | Read result |
| mem_ce_n | output | 1 | RAM chip select, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_addr | output | 15 | RAM address |
| mem_dq_o | output | 8 | Data to drive on the RAM bus |
| mem_dq_oe | output | 1 | Drive enable for the RAM bus pads |
| mem_dq_i | input | 8 | Value sampled from the RAM bus pins |

## Verification
The hardest situation to reach is a write that follows a read as closely as the port allows, while the RAM model is still inside its output-release window. The RAM model returns garbage until the full access count has elapsed. It keeps flagging contention for the release cycles after output enable rises. The bench presents the next write request in the cycle the read response appears. The model then catches a controller that samples early or drives the bus too soon.

// File: rtl/asram_pkg.sv
`timescale 1ns/1ps
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RD    = 3'd1,
    ST_REL   = 3'd2,
    ST_WSET  = 3'd3,
    ST_WPUL  = 3'd4,
    ST_WHOLD = 3'd5
  } asram_st_e;

  // Whole clock cycles covering a time span; never less than one.
  function automatic int span_cycles(input int t_ps, input int clk_ps);
    int n;
    n = (t_ps + clk_ps - 1) / clk_ps;
    return (n < 1) ? 1 : n;
  endfunction

endpackage

// File: rtl/asram_wait.sv
`timescale 1ns/1ps
module asram_wait #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/asram_seq.sv
`timescale 1ns/1ps
module asram_seq
  import asram_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8,
  parameter int RD_CYC = 5,
  parameter int HZ_CYC = 3,
  parameter int WP_CYC = 4,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic              tmr_load,
  output logic [CNT_W-1:0]  tmr_val,
  input  logic              tmr_zero
);
  localparam logic [CNT_W-1:0] RD_LD = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] HZ_LD = CNT_W'(HZ_CYC - 1);
  localparam logic [CNT_W-1:0] WP_LD = CNT_W'(WP_CYC - 1);

  asram_st_e state;

  // Wait counter is loaded on entry to each timed phase.
  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state)
      ST_IDLE: if (req_valid && !req_write) begin tmr_load = 1'b1; tmr_val = RD_LD; end
      ST_RD:   if (tmr_zero)                begin tmr_load = 1'b1; tmr_val = HZ_LD; end
      ST_WSET:                              begin tmr_load = 1'b1; tmr_val = WP_LD; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      req_ready <= 1'b1;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      mem_ce_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_addr  <= '0;
      mem_dq_o  <= '0;
      mem_dq_oe <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (state)
        ST_IDLE: if (req_valid) begin
          req_ready <= 1'b0;
          mem_addr  <= req_addr;
          mem_ce_n  <= 1'b0;
          if (req_write) begin
            mem_dq_o  <= req_wdata;
            mem_dq_oe <= 1'b1;
            state     <= ST_WSET;
          end else begin
            mem_oe_n  <= 1'b0;
            state     <= ST_RD;
          end
        end
        ST_RD: if (tmr_zero) begin
          rsp_rdata <= mem_dq_i;
          rsp_valid <= 1'b1;
          mem_ce_n  <= 1'b1;
          mem_oe_n  <= 1'b1;
          state     <= ST_REL;
        end
        ST_REL: if (tmr_zero) begin
          req_ready <= 1'b1;
          state     <= ST_IDLE;
        end
        ST_WSET: begin
          mem_we_n <= 1'b0;
          state    <= ST_WPUL;
        end
        ST_WPUL: if (tmr_zero) begin
          mem_we_n <= 1'b1;
          state    <= ST_WHOLD;
        end
        ST_WHOLD: begin
          mem_ce_n  <= 1'b1;
          mem_dq_oe <= 1'b0;
          req_ready <= 1'b1;
          rsp_valid <= 1'b1;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2
  idle_standby_chk: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (mem_ce_n && !mem_dq_oe));
  // R6
  no_drive_on_read_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> !mem_dq_oe);
  // R6
  no_oe_we_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(!mem_oe_n && !mem_we_n));
  // R5
  release_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_oe_n) |-> !req_ready);
  // R7
  write_setup_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_we_n) |-> ($past(mem_dq_oe) && !$past(mem_ce_n)));
  // R8
  write_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!mem_we_n && !$past(mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_o)));
  // R9
  write_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (mem_dq_oe && !mem_ce_n));
endmodule

// File: rtl/asram_ctrl.sv
`timescale 1ns/1ps
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W     = 15,
  parameter int DATA_W     = 8,
  parameter int CLK_PS     = 5000,
  parameter int T_ACC_PS   = 25000,
  parameter int T_REL_PS   = 12000,
  parameter int T_WPUL_PS  = 20000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);
  localparam int RD_CYC = span_cycles(T_ACC_PS, CLK_PS);
  localparam int HZ_CYC = span_cycles(T_REL_PS, CLK_PS);
  localparam int WP_CYC = span_cycles(T_WPUL_PS, CLK_PS);
  localparam int MAX_A  = (RD_CYC > HZ_CYC) ? RD_CYC : HZ_CYC;
  localparam int MAX_C  = (MAX_A > WP_CYC) ? MAX_A : WP_CYC;
  localparam int CNT_W  = $clog2(MAX_C + 1);

  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_zero;

  asram_wait #(.CNT_W(CNT_W)) wait_i (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  asram_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RD_CYC(RD_CYC),
    .HZ_CYC(HZ_CYC), .WP_CYC(WP_CYC), .CNT_W(CNT_W)
  ) seq_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_addr(mem_addr), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
    .mem_dq_i(mem_dq_i),
    .tmr_load(tmr_load), .tmr_val(tmr_val), .tmr_zero(tmr_zero)
  );
endmodule

// File: tb/asram_ctrl_tb_top.sv
`timescale 1ns/1ps
module asram_ctrl_tb_top;
  localparam int RD_N = 5;
  localparam int HZ_N = 3;
  localparam int WP_N = 4;

  typedef struct packed {
    logic        wr;
    logic [14:0] addr;
    logic [7:0]  data;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{1'b1, 15'h0000, 8'h11}, '{1'b0, 15'h0000, 8'h00},
    '{1'b1, 15'h7FFF, 8'hEE}, '{1'b0, 15'h7FFF, 8'h00},
    '{1'b0, 15'h1234, 8'h00}, '{1'b1, 15'h1234, 8'hC3},
    '{1'b1, 15'h1234, 8'h3C}, '{1'b0, 15'h1234, 8'h00},
    '{1'b1, 15'h4000, 8'h00}, '{1'b1, 15'h4001, 8'hFF},
    '{1'b0, 15'h4000, 8'h00}, '{1'b0, 15'h4001, 8'h00}
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_ready, req_write;
  logic [14:0] req_addr;
  logic [7:0]  req_wdata;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata;
  logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [14:0] mem_addr;
  logic [7:0]  mem_dq_o, mem_dq_i;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  asram_ctrl dut_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_addr(mem_addr), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
    .mem_dq_i(mem_dq_i)
  );

  // ---------------- RAM model, evaluated once per cycle ----------------
  logic [7:0]  ram [int];
  logic [7:0]  shadow [int];
  int          rd_cnt = 0, wl_cnt = 0, hz_left = 0;
  logic [14:0] wr_addr, rd_addr;
  logic [7:0]  wr_data;
  int          contend_viol = 0, wpulse_viol = 0, idle_viol = 0;

  function automatic logic [7:0] init_byte(input logic [14:0] a);
    return a[7:0] ^ {1'b0, a[14:8]} ^ 8'h5A;
  endfunction

  function automatic logic [7:0] ram_rd(input logic [14:0] a);
    return ram.exists(int'(a)) ? ram[int'(a)] : init_byte(a);
  endfunction

  function automatic logic [7:0] exp_rd(input logic [14:0] a);
    return shadow.exists(int'(a)) ? shadow[int'(a)] : init_byte(a);
  endfunction

  wire ram_drv = !mem_ce_n && !mem_oe_n && mem_we_n;
  assign mem_dq_i = (ram_drv && rd_cnt >= RD_N && rd_addr == mem_addr)
                    ? ram_rd(mem_addr) : 8'hB7;

  always @(negedge clk) begin
    if (rst) begin
      rd_cnt = 0; wl_cnt = 0; hz_left = 0;
    end else begin
      if (mem_dq_oe && (ram_drv || hz_left > 0)) contend_viol++;
      if (!mem_oe_n && !mem_we_n) contend_viol++;
      if (req_ready && (!mem_ce_n || mem_dq_oe)) idle_viol++;
      if (ram_drv) hz_left = HZ_N; else if (hz_left > 0) hz_left--;
      if (ram_drv && (rd_cnt == 0 || rd_addr == mem_addr)) begin
        rd_addr = mem_addr; rd_cnt++;
      end else if (ram_drv) begin
        rd_addr = mem_addr; rd_cnt = 1;
      end else rd_cnt = 0;
      if (!mem_ce_n && !mem_we_n) begin
        if (!mem_dq_oe || !mem_oe_n) wpulse_viol++;
        if (wl_cnt > 0 && (mem_addr != wr_addr || mem_dq_o != wr_data)) wpulse_viol++;
        wr_addr = mem_addr; wr_data = mem_dq_o; wl_cnt++;
      end else if (wl_cnt > 0) begin
        if (wl_cnt != WP_N) wpulse_viol++;
        ram[int'(wr_addr)] = wr_data;
        wl_cnt = 0;
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input bit w, input logic [14:0] a, input logic [7:0] d);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic run_txn(input bit w, input logic [14:0] a, input logic [7:0] d,
                         output logic [7:0] rd, output int lat);
    issue(w, a, d);
    lat = 1;
    while (!rsp_valid && lat < 50) begin @(negedge clk); lat++; end
    rd = rsp_rdata;
    if (w) shadow[int'(a)] = d;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  // ---------------- main ----------------
  initial begin
    logic [7:0] rd;
    int lat;
    rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(mem_ce_n && mem_oe_n && mem_we_n, "R1 strobes", {mem_ce_n, mem_oe_n, mem_we_n}, 3'b111);
    chk(!mem_dq_oe && req_ready && !rsp_valid, "R1 bus/handshake",
        {mem_dq_oe, req_ready, rsp_valid}, 3'b010);

    // Vector table walk
    for (int i = 0; i < 12; i++) begin
      logic [7:0] e;
      e = exp_rd(VECS[i].addr);
      run_txn(VECS[i].wr, VECS[i].addr, VECS[i].data, rd, lat);
      if (VECS[i].wr) chk(lat == 7, "R9 write latency", lat, 7);
      else begin
        chk(rd == e, "R4 read data", rd, e);
        chk(lat == 6, "R3 read latency", lat, 6);
      end
    end

    // Directed read timing at a fresh address
    issue(1'b0, 15'h2AA5, 8'h00);
    for (int k = 1; k <= RD_N; k++) begin
      chk(!mem_ce_n && !mem_oe_n && mem_we_n && mem_addr == 15'h2AA5, "R3 read window",
          {mem_ce_n, mem_oe_n, mem_we_n}, 3'b001);
      @(negedge clk);
    end
    chk(rsp_valid && rsp_rdata == exp_rd(15'h2AA5), "R4 capture", rsp_rdata, exp_rd(15'h2AA5));
    chk(mem_oe_n && mem_ce_n, "R4 strobes release", {mem_ce_n, mem_oe_n}, 2'b11);
    for (int k = 0; k < HZ_N; k++) begin
      chk(!req_ready, "R5 release gap", req_ready, 0);
      req_valid = 1'b1; req_write = 1'b1; req_addr = 15'h2AA5; req_wdata = 8'h96;
      @(negedge clk);
    end
    chk(req_ready && mem_ce_n && !mem_dq_oe, "R5 ready after gap", req_ready, 1);
    // Write held pending during the gap is taken now: check write timing (R7-R9)
    @(negedge clk);
    req_valid = 1'b0;
    chk(!mem_ce_n && mem_we_n && mem_oe_n && mem_dq_oe && mem_addr == 15'h2AA5 && mem_dq_o == 8'h96,
        "R7 write setup", {mem_ce_n, mem_we_n, mem_dq_oe}, 3'b011);
    for (int k = 0; k < WP_N; k++) begin
      @(negedge clk);
      chk(!mem_we_n && mem_oe_n && mem_dq_o == 8'h96, "R8 write pulse", mem_we_n, 0);
    end
    @(negedge clk);
    chk(mem_we_n && mem_dq_oe && !mem_ce_n, "R9 hold cycle", {mem_we_n, mem_dq_oe, mem_ce_n}, 3'b110);
    @(negedge clk);
    chk(mem_ce_n && !mem_dq_oe && rsp_valid && req_ready, "R9 release", {mem_ce_n, mem_dq_oe}, 2'b10);
    shadow[int'(15'h2AA5)] = 8'h96;
    run_txn(1'b0, 15'h2AA5, 8'h00, rd, lat);
    chk(rd == 8'h96, "R4 read-back after turnaround", rd, 8'h96);

    repeat (3) @(negedge clk);
    chk(contend_viol == 0, "R6 bus contention", contend_viol, 0);
    chk(wpulse_viol == 0, "R8 write pulse model", wpulse_viol, 0);
    chk(idle_viol == 0, "R2 idle standby", idle_viol, 0);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule